// File: doc/BRIEF.md
# Indirect-Access Next-Block Pointer Store

This block holds the next-block pointer of every buffer block in a chain of linked blocks. It has one pointer entry per block, and each entry names the block that follows. A host never addresses the memory directly. It loads a 16-bit pointer data register. It then writes a 16-bit command register, which names the block, chooses read or write and launches the access. While the access runs, a read-only busy bit in the command register stays high, and the host polls that bit until it drops. A write that would make a block point to itself is refused and raises a sticky error bit.

A second, internal port lets a list-walking engine fetch the pointer of any block. This port has priority on the single RAM port. A host access that finds the RAM taken waits in its arbitration state with busy held high.

The sequencer is a four-state machine:
- `ST_IDLE` waits for an accepted command write and moves to `ST_ARB` (start).
- `ST_ARB` stays put while the walker holds the RAM (stall). When the RAM is free it issues the host access (grant) and moves to `ST_ACC`.
- `ST_ACC` captures the read data and moves to `ST_DONE`.
- `ST_DONE` returns to `ST_IDLE` and busy drops.

Top module: `lnk_ptr_store`

## Requirements
- R1: After a synchronous reset, the command register and the data register both read 0x0000 and `walk_vld` is 0.
- R2: Register layout. `host_sel`=0 selects the command register and `host_sel`=1 selects the data register. In the command register, bits 9:0 hold the block index, bit 14 is the direction (1 = read, 0 = write), bit 15 is the read-only busy flag, bit 13 is the error flag, and bits 12:10 read as 0. In the data register, bits 9:0 hold the pointer and bits 15:10 read as 0.
- R3: A write command stores the data register's pointer into the entry of the selected block.
- R4: A read command loads the selected entry into the data register by the time busy clears.
- R5: An accepted command sets busy from the following cycle. With no contention, busy reads 1 for the three cycles after the accepting clock edge and reads 0 after the third edge that follows it.
- R6: A write whose pointer equals the selected index leaves the RAM unchanged, completes normally and sets the error flag (bit 13). The flag stays set until a command write with bit 13 = 1 clears it.
- R7: A command-register write that arrives while busy is 1 is ignored. It does not alter the index, the direction or the access in progress.
- R8: When `walk_req` is high at a clock edge, `walk_ptr` holds the entry at `walk_idx` and `walk_vld` is 1 after the next clock edge.
- R9: The walker has priority. While `walk_req` is high, a pending host access waits with busy held at 1. It completes three edges after `walk_req` drops.
- R10: The data register changes only on host writes to it and on completed read commands. Write commands and walker reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected register read value |
| walk_req | input | 1 | Walker read request |
| walk_idx | input | 10 | Block whose pointer the walker reads |
| walk_ptr | output | 10 | Pointer returned to the walker |
| walk_vld | output | 1 | `walk_ptr` is valid |

## Verification
The bench counts busy cycle by cycle. A sequencer with a missing or an extra state would clear busy one edge early or one edge late. A self-pointing write is followed by a read-back of the same entry. A guard that only flagged the error, or that compared against the wrong operand, would show a corrupted pointer or a missing error bit. A command written during an access is checked at the index field and in the RAM, which catches a design that restarts on it. The walker is held high across a pending host read, which catches a design that lets the host through or drops busy early. Walker reads and write commands are then shown to leave the data register alone.

// File: rtl/lps_pkg.sv
package lps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_ACC,
        ST_DONE
    } seq_state_t;

    localparam int REG_W    = 16;
    localparam int BIT_BUSY = 15;
    localparam int BIT_DIR  = 14;
    localparam int BIT_ERR  = 13;
endpackage

// File: rtl/lps_mem.sv
module lps_mem #(
    parameter int IDX_W = 10,
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] addr,
    input  logic [PTR_W-1:0] din,
    output logic [PTR_W-1:0] dout
);
    localparam int DEPTH = 1 << IDX_W;

    logic [PTR_W-1:0] store [DEPTH];

    // Single port, registered read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= din;
        end
        if (rd_en) begin
            dout <= store[addr];
        end
    end
endmodule

// File: rtl/lps_host_regs.sv
module lps_host_regs
    import lps_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_sel,
    input  logic [REG_W-1:0] host_wdata,
    input  logic             busy,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_data,
    input  logic             err_set,
    output logic             start,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_dir,
    output logic [IDX_W-1:0] cur_ptr,
    output logic [REG_W-1:0] host_rdata
);
    logic err_q;
    logic cmd_acc;

    // A command write counts only when no access is running.
    assign cmd_acc = host_wr && !host_sel && !busy;
    assign start   = cmd_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= '0;
            cur_dir <= 1'b0;
            err_q   <= 1'b0;
            cur_ptr <= '0;
        end else begin
            if (cmd_acc) begin
                cur_idx <= host_wdata[IDX_W-1:0];
                cur_dir <= host_wdata[BIT_DIR];
            end
            if (err_set) begin
                err_q <= 1'b1;
            end else if (cmd_acc && host_wdata[BIT_ERR]) begin
                err_q <= 1'b0;
            end
            if (cap_en) begin
                cur_ptr <= cap_data;
            end else if (host_wr && host_sel) begin
                cur_ptr <= host_wdata[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_sel) begin
            host_rdata[IDX_W-1:0] = cur_ptr;
        end else begin
            host_rdata[IDX_W-1:0] = cur_idx;
            host_rdata[BIT_BUSY]  = busy;
            host_rdata[BIT_DIR]   = cur_dir;
            host_rdata[BIT_ERR]   = err_q;
        end
    end
endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cur_dir,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] cur_ptr,
    input  logic             walk_req,
    input  logic [IDX_W-1:0] walk_idx,
    output logic             busy,
    output logic             cap_en,
    output logic             err_set,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [IDX_W-1:0] mem_addr,
    output logic [IDX_W-1:0] mem_din,
    output logic             walk_vld
);
    seq_state_t state_q, state_d;
    logic grant;
    logic self_ptr;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            walk_vld <= 1'b0;
        end else begin
            state_q  <= state_d;
            walk_vld <= walk_req;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d  = state_q;
        grant    = 1'b0;
        cap_en   = 1'b0;
        busy     = 1'b1;
        self_ptr = (cur_ptr == cur_idx);
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) state_d = ST_ARB;
            end
            ST_ARB: begin
                if (!walk_req) begin
                    grant   = 1'b1;
                    state_d = ST_ACC;
                end
            end
            ST_ACC: begin
                cap_en  = cur_dir;
                state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        mem_rd   = walk_req || (grant && cur_dir);
        mem_wr   = grant && !cur_dir && !self_ptr;
        err_set  = grant && !cur_dir && self_ptr;
        mem_addr = walk_req ? walk_idx : cur_idx;
        mem_din  = cur_ptr;
    end
endmodule

// File: rtl/lnk_ptr_store.sv
module lnk_ptr_store
    import lps_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             walk_req,
    input  logic [IDX_W-1:0] walk_idx,
    output logic [IDX_W-1:0] walk_ptr,
    output logic             walk_vld
);
    logic             start;
    logic             busy;
    logic             cap_en;
    logic             err_set;
    logic             cur_dir;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] cur_ptr;
    logic             mem_rd;
    logic             mem_we;
    logic [IDX_W-1:0] mem_addr;
    logic [IDX_W-1:0] mem_din;
    logic [IDX_W-1:0] mem_dout;

    lps_host_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .busy(busy), .cap_en(cap_en),
        .cap_data(mem_dout), .err_set(err_set), .start(start),
        .cur_idx(cur_idx), .cur_dir(cur_dir), .cur_ptr(cur_ptr),
        .host_rdata(host_rdata)
    );

    lps_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .cur_dir(cur_dir),
        .cur_idx(cur_idx), .cur_ptr(cur_ptr), .walk_req(walk_req),
        .walk_idx(walk_idx), .busy(busy), .cap_en(cap_en),
        .err_set(err_set), .mem_rd(mem_rd), .mem_wr(mem_we),
        .mem_addr(mem_addr), .mem_din(mem_din), .walk_vld(walk_vld)
    );

    lps_mem #(.IDX_W(IDX_W), .PTR_W(IDX_W)) u_mem (
        .clk(clk), .rd_en(mem_rd), .wr_en(mem_we), .addr(mem_addr),
        .din(mem_din), .dout(mem_dout)
    );

    assign walk_ptr = mem_dout;
endmodule

// File: rtl/lnk_ptr_store_chk.sv
module lnk_ptr_store_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_sel,
    input logic             busy,
    input logic             walk_req,
    input logic             walk_vld,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_addr,
    input logic [IDX_W-1:0] mem_din,
    input logic [IDX_W-1:0] cur_idx
);
    AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_sel && !busy) |=> busy); // R5
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_sel && busy) |=> $stable(cur_idx)); // R7
    AST_NO_SELF_LINK: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr != mem_din)); // R6
    AST_WALKER_FIRST: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !walk_req); // R9
    AST_WALK_VALID: assert property (@(posedge clk) disable iff (rst)
        walk_req |=> walk_vld); // R8
endmodule

bind lnk_ptr_store lnk_ptr_store_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .busy(busy), .walk_req(walk_req), .walk_vld(walk_vld),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_din(mem_din),
    .cur_idx(cur_idx)
);

// File: tb/lnk_ptr_store_tb_top.sv
module lnk_ptr_store_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        walk_req = 1'b0;
    logic [9:0]  walk_idx = '0;
    logic [9:0]  walk_ptr;
    logic        walk_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lnk_ptr_store dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .walk_req(walk_req), .walk_idx(walk_idx), .walk_ptr(walk_ptr),
        .walk_vld(walk_vld)
    );

    // {index, pointer}
    localparam logic [19:0] VEC [8] = '{
        {10'h000, 10'h001}, {10'h3FF, 10'h000}, {10'h001, 10'h3FF},
        {10'h155, 10'h2AA}, {10'h2AA, 10'h155}, {10'h200, 10'h1FF},
        {10'h1FF, 10'h200}, {10'h07F, 10'h080}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic sel, output logic [15:0] v);
        host_sel = sel;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 40; i++) begin
            hread(1'b0, v);
            if (!v[15]) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        hread(1'b0, v); chk("R1 ctrl", v, 16'h0000);
        hread(1'b1, v); chk("R1 data", v, 16'h0000);
        chk("R1 walk_vld", {15'd0, walk_vld}, 16'h0000);

        // R3 table writes, R4 read-back
        foreach (VEC[k]) begin
            hwrite(1'b1, {6'd0, VEC[k][9:0]});
            hwrite(1'b0, {6'd0, VEC[k][19:10]});
            wait_idle();
        end
        foreach (VEC[k]) begin
            hwrite(1'b0, 16'h4000 | {6'd0, VEC[k][19:10]});
            wait_idle();
            hread(1'b1, v); chk("R3/R4 table", v, {6'd0, VEC[k][9:0]});
        end

        // R5 exact latency on a read of block 0x200
        hwrite(1'b0, 16'h4200);
        hread(1'b0, v); chk("R5 busy e0", {15'd0, v[15]}, 16'h1);
        chk("R2 ctrl fields", v & 16'h43FF, 16'h4200);
        @(negedge clk); hread(1'b0, v); chk("R5 busy e1", {15'd0, v[15]}, 16'h1);
        @(negedge clk); hread(1'b0, v); chk("R5 busy e2", {15'd0, v[15]}, 16'h1);
        @(negedge clk); hread(1'b0, v); chk("R5 busy e3", {15'd0, v[15]}, 16'h0);
        hread(1'b1, v); chk("R4 data", v, 16'h01FF);

        // R2 reserved bits
        hwrite(1'b0, 16'h5D55);
        wait_idle();
        hread(1'b0, v); chk("R2 ctrl reserved", v, 16'h4155);
        hwrite(1'b1, 16'hFFFF);
        hread(1'b1, v); chk("R2 data reserved", v, 16'h03FF);

        // R6 self pointer refused
        hwrite(1'b1, 16'h0155);
        hwrite(1'b0, 16'h0155);
        wait_idle();
        hread(1'b0, v); chk("R6 err set", {15'd0, v[13]}, 16'h1);
        hwrite(1'b0, 16'h4155);
        wait_idle();
        hread(1'b1, v); chk("R6 ram unchanged", v, 16'h02AA);
        hread(1'b0, v); chk("R6 err sticky", {15'd0, v[13]}, 16'h1);
        hwrite(1'b0, 16'h6155);
        wait_idle();
        hread(1'b0, v); chk("R6 err cleared", {15'd0, v[13]}, 16'h0);

        // R7 command while busy ignored
        hwrite(1'b0, 16'h43FF);
        hwrite(1'b0, 16'h0001);
        wait_idle();
        hread(1'b0, v); chk("R7 idx/dir kept", v, 16'h43FF);
        hread(1'b1, v); chk("R7 read completed", v, 16'h0000);
        hwrite(1'b0, 16'h4001);
        wait_idle();
        hread(1'b1, v); chk("R7 entry 1 untouched", v, 16'h03FF);

        // R8 walker read
        @(negedge clk); walk_req = 1'b1; walk_idx = 10'h2AA;
        @(negedge clk); walk_req = 1'b0;
        chk("R8 walk_vld", {15'd0, walk_vld}, 16'h1);
        chk("R8 walk_ptr", {6'd0, walk_ptr}, 16'h0155);

        // R9 walker priority
        @(negedge clk); walk_req = 1'b1; walk_idx = 10'h000;
        hwrite(1'b0, 16'h4001);
        repeat (6) @(negedge clk);
        hread(1'b0, v); chk("R9 busy held", {15'd0, v[15]}, 16'h1);
        chk("R9 walker served", {6'd0, walk_ptr}, 16'h0001);
        walk_req = 1'b0;
        @(negedge clk); @(negedge clk);
        hread(1'b0, v); chk("R9 busy e2", {15'd0, v[15]}, 16'h1);
        @(negedge clk);
        hread(1'b0, v); chk("R9 busy e3", {15'd0, v[15]}, 16'h0);
        hread(1'b1, v); chk("R9 data", v, 16'h03FF);

        // R10 data register not touched by walker or write command
        hwrite(1'b1, 16'h0123);
        @(negedge clk); walk_req = 1'b1; walk_idx = 10'h200;
        @(negedge clk); walk_req = 1'b0;
        hread(1'b1, v); chk("R10 after walker", v, 16'h0123);
        hwrite(1'b0, 16'h0300);
        wait_idle();
        hread(1'b1, v); chk("R10 after write cmd", v, 16'h0123);
        hwrite(1'b0, 16'h4300);
        wait_idle();
        hread(1'b1, v); chk("R10 R3 write stored", v, 16'h0123);

        finish_run();
    end
endmodule